// File: doc/BRIEF.md
# Daisy-Chain Readout Sequencer

This controller runs one token-passing readout of a chain of data sources. Two events must both be seen before a readout may begin: a capture strobe, which freezes the data in every source, and a transport command, which asks for the data to be shipped. The two can arrive in either order. When transport comes first, the sequencer parks it and waits for the capture before it acts.

Once both events are in, the sequencer pulls its active-low outgoing token low. The first source then starts to drive data, and each source passes the token to the next. The last source in the chain returns the token, active low, to the sequencer. One clock later the outgoing token is released and the sequencer is idle again. The shared active-low data-valid line, which reads high when no source drives it, goes through a synchroniser to the data-available output.

Misordered events are ignored and latched into two sticky error flags: a capture that arrives while a readout is still owed, and a transport that has no capture waiting for it. A disable input stops any launch. The current state can be read on a port.

Top module: `chain_readout_seq`

## Requirements
- R1: During reset and right after it, `chain_en_out_n_o` and `dav_n_o` are 1, `seq_state_o` is 0 (idle) and both error flags are 0.
- R2: In the captured state (code 1), a transport pulse sampled at a clock edge moves `seq_state_o` to 3 (readout) and drives `chain_en_out_n_o` low at that same edge.
- R3: A transport pulse in the idle state moves `seq_state_o` to 2 (transport pending) and leaves the token high. A later capture pulse then launches the readout: state 3, token low.
- R4: A capture and a transport in the same idle cycle launch the readout at once.
- R5: In readout, a low `chain_en_in_n_i` moves the state to 4 (done) at the next edge while the token stays low. At the edge after that, the token returns high and the state returns to 0.
- R6: If `launch_disable_i` is 1 in the cycle where a launch would occur, the token stays high and the state returns to 0.
- R7: `dav_n_o` equals `data_valid_n_i` delayed by SYNC_STAGES clock edges (2 by default).
- R8: A capture pulse in state 1, 3 or 4 sets the sticky `overrun_err_o` at the next edge and leaves the state unchanged.
- R9: A transport pulse in state 2, 3 or 4 sets the sticky `orphan_err_o` at the next edge and leaves the state unchanged.
- R10: `err_clear_i` clears both flags at the next edge. If an error event occurs in the same cycle, that flag is set instead.
- R11: Outside state 3, a low `chain_en_in_n_i` has no effect on the state or on the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Capture strobe, one-cycle pulse |
| transport_i | input | 1 | Transport command, one-cycle pulse |
| launch_disable_i | input | 1 | Control bit: 1 blocks the token launch |
| err_clear_i | input | 1 | Clears the sticky error flags |
| chain_en_in_n_i | input | 1 | Returning token from the last source, active low |
| data_valid_n_i | input | 1 | Shared data-valid line, active low, idles high |
| chain_en_out_n_o | output | 1 | Outgoing token to the first source, active low |
| dav_n_o | output | 1 | Synchronised data-available, active low |
| seq_state_o | output | 3 | State code: 0 idle, 1 captured, 2 transport pending, 3 readout, 4 done |
| overrun_err_o | output | 1 | Sticky flag: capture during an unfinished cycle |
| orphan_err_o | output | 1 | Sticky flag: transport with no capture pending |

## Verification
On every cycle, the assertions check that the token falls only after a capture or transport pulse and never while the disable bit is set. They also check that a returning token in readout leads to the done state, that done always releases the token and returns to idle, and that a capture during readout raises the overrun flag. Some behaviour shows only in the bench's scenarios: both event orders and the simultaneous case, a disabled launch, the exact synchroniser latency of the data-available output, clear racing a new error, and a returning token ignored while idle. A constrained-random run with a bench reference model then covers the same rules over long mixed sequences.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_CAPTURED = 3'd1,
        ST_PEND_TR  = 3'd2,
        ST_READOUT  = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       tok_n;
    } fsm_regs_t;

    localparam int ERR_OVERRUN = 0;
    localparam int ERR_ORPHAN  = 1;
    localparam int ERR_COUNT   = 2;

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_d;
    logic [LAST:0] stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i <= LAST; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[LAST];

    initial begin
        assert_stage_count_R7: assert (STAGES >= 1);
    end

endmodule

// File: rtl/crs_sticky.sv
module crs_sticky #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_d;
    logic [WIDTH-1:0] flag_q;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            always_comb begin
                if (set_i[g]) begin
                    flag_d[g] = 1'b1;
                end else if (clr_i) begin
                    flag_d[g] = 1'b0;
                end else begin
                    flag_d[g] = flag_q[g];
                end
            end

            assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> flag_q[g]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import crs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  logic       transport_i,
    input  logic       launch_disable_i,
    input  logic       chain_en_in_n_i,
    output logic       tok_n_o,
    output seq_state_e state_o,
    output logic       overrun_evt_o,
    output logic       orphan_evt_o
);
    fsm_regs_t regs_d;
    fsm_regs_t regs_q;
    logic      launch;

    always_comb begin
        regs_d        = regs_q;
        launch        = 1'b0;
        overrun_evt_o = 1'b0;
        orphan_evt_o  = 1'b0;

        case (regs_q.state)
            ST_IDLE: begin
                if (capture_i && transport_i) begin
                    launch = 1'b1;
                end else if (capture_i) begin
                    regs_d.state = ST_CAPTURED;
                end else if (transport_i) begin
                    regs_d.state = ST_PEND_TR;
                end
            end
            ST_CAPTURED: begin
                launch        = transport_i;
                overrun_evt_o = capture_i;
            end
            ST_PEND_TR: begin
                launch       = capture_i;
                orphan_evt_o = transport_i;
            end
            ST_READOUT: begin
                if (!chain_en_in_n_i) begin
                    regs_d.state = ST_DONE;
                end
                overrun_evt_o = capture_i;
                orphan_evt_o  = transport_i;
            end
            ST_DONE: begin
                regs_d.state  = ST_IDLE;
                overrun_evt_o = capture_i;
                orphan_evt_o  = transport_i;
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase

        if (launch) begin
            regs_d.state = launch_disable_i ? ST_IDLE : ST_READOUT;
        end

        regs_d.tok_n = !((regs_d.state == ST_READOUT) || (regs_d.state == ST_DONE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.tok_n <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tok_n_o = regs_q.tok_n;
    assign state_o = regs_q.state;

    assert_launch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tok_n_o) |-> ($past(transport_i) || $past(capture_i)));

    assert_disable_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tok_n_o) |-> !$past(launch_disable_i));

    assert_return_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_READOUT && !chain_en_in_n_i) |=> (regs_q.state == ST_DONE));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_DONE) |=> (tok_n_o && regs_q.state == ST_IDLE));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_IDLE && !capture_i && !transport_i) |=> (tok_n_o && regs_q.state == ST_IDLE));

endmodule

// File: rtl/chain_readout_seq.sv
module chain_readout_seq
    import crs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic               transport_i,
    input  logic               launch_disable_i,
    input  logic               err_clear_i,
    input  logic               chain_en_in_n_i,
    input  logic               data_valid_n_i,
    output logic               chain_en_out_n_o,
    output logic               dav_n_o,
    output logic [STATE_W-1:0] seq_state_o,
    output logic               overrun_err_o,
    output logic               orphan_err_o
);
    seq_state_e           state;
    logic                 overrun_evt;
    logic                 orphan_evt;
    logic [ERR_COUNT-1:0] err_set;
    logic [ERR_COUNT-1:0] err_flags;

    crs_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .capture_i        (capture_i),
        .transport_i      (transport_i),
        .launch_disable_i (launch_disable_i),
        .chain_en_in_n_i  (chain_en_in_n_i),
        .tok_n_o          (chain_en_out_n_o),
        .state_o          (state),
        .overrun_evt_o    (overrun_evt),
        .orphan_evt_o     (orphan_evt)
    );

    always_comb begin
        err_set              = '0;
        err_set[ERR_OVERRUN] = overrun_evt;
        err_set[ERR_ORPHAN]  = orphan_evt;
    end

    crs_sticky #(
        .WIDTH (ERR_COUNT)
    ) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (err_clear_i),
        .flag_o (err_flags)
    );

    crs_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_dav_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (data_valid_n_i),
        .q_o   (dav_n_o)
    );

    assign seq_state_o   = state;
    assign overrun_err_o = err_flags[ERR_OVERRUN];
    assign orphan_err_o  = err_flags[ERR_ORPHAN];

    assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && seq_state_o == 3'd3) |=> overrun_err_o);

    assert_orphan_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (transport_i && seq_state_o == 3'd2) |=> orphan_err_o);

    assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear_i && seq_state_o == 3'd0) |=> (!overrun_err_o && !orphan_err_o));

endmodule

// File: tb/chain_readout_seq_bench.sv
module chain_readout_seq_bench;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap = 1'b0, tr = 1'b0, dis = 1'b0, clr = 1'b0, cin_n = 1'b1, dv_n = 1'b1;
    logic tok_n, dav_n, ovr, orph;
    logic [2:0] st;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // reference model
    int   m_st;
    logic m_tok, m_ovr, m_orph;
    logic [SYNC-1:0] m_dv;

    always #2.5 clk = ~clk;

    chain_readout_seq #(.SYNC_STAGES(SYNC)) u_chain_readout_seq (
        .clk(clk), .rst_n(rst_n), .capture_i(cap), .transport_i(tr),
        .launch_disable_i(dis), .err_clear_i(clr), .chain_en_in_n_i(cin_n),
        .data_valid_n_i(dv_n), .chain_en_out_n_o(tok_n), .dav_n_o(dav_n),
        .seq_state_o(st), .overrun_err_o(ovr), .orphan_err_o(orph)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // model of R2..R11, applied to the inputs seen at one edge
    function automatic int next_state(int s);
        int ns = s;
        bit launch = 0;
        case (s)
            0: if (cap && tr) launch = 1; else if (cap) ns = 1; else if (tr) ns = 2;
            1: launch = tr;
            2: launch = cap;
            3: if (!cin_n) ns = 4;
            default: ns = 0;
        endcase
        if (launch) ns = dis ? 0 : 3;
        return ns;
    endfunction

    task automatic model_edge();
        int ns = next_state(m_st);
        bit ov = cap && (m_st == 1 || m_st == 3 || m_st == 4);
        bit orp = tr && (m_st == 2 || m_st == 3 || m_st == 4);
        m_ovr  = ov  ? 1'b1 : (clr ? 1'b0 : m_ovr);
        m_orph = orp ? 1'b1 : (clr ? 1'b0 : m_orph);
        m_st   = ns;
        m_tok  = !(ns == 3 || ns == 4);
        m_dv   = {m_dv[SYNC-2:0], dv_n};
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_idle();
        cap = 0; tr = 0; clr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        pulse_idle(); dis = 0; cin_n = 1; dv_n = 1;
        tick(); tick();
        rst_n = 1;
        m_st = 0; m_tok = 1; m_ovr = 0; m_orph = 0; m_dv = '1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1
        chk("R1 state", st, 0); chk("R1 token", tok_n, 1); chk("R1 dav", dav_n, 1);
        chk("R1 overrun", ovr, 0); chk("R1 orphan", orph, 0);

        // R11: returning token while idle
        cin_n = 0; tick(); cin_n = 1;
        chk("R11 state", st, 0); chk("R11 token", tok_n, 1);

        // R2: capture then transport
        cap = 1; tick(); cap = 0;
        chk("R2 captured", st, 1); chk("R2 token high", tok_n, 1);
        tr = 1; tick(); tr = 0;
        chk("R2 readout", st, 3); chk("R2 token low", tok_n, 0);

        // R8: capture during readout
        cap = 1; tick(); cap = 0;
        chk("R8 overrun", ovr, 1); chk("R8 state", st, 3);

        // R5: return token and release
        cin_n = 0; tick(); cin_n = 1;
        chk("R5 done", st, 4); chk("R5 token low", tok_n, 0);
        tick();
        chk("R5 idle", st, 0); chk("R5 token high", tok_n, 1);

        // R10: clear
        clr = 1; tick(); clr = 0;
        chk("R10 overrun cleared", ovr, 0);

        // R3 and R9: transport first, duplicate transport
        tr = 1; tick();
        chk("R3 pending", st, 2); chk("R3 token high", tok_n, 1);
        tick(); tr = 0;
        chk("R9 orphan", orph, 1); chk("R9 state", st, 2);
        cap = 1; tick(); cap = 0;
        chk("R3 launched", st, 3); chk("R3 token low", tok_n, 0);
        cin_n = 0; tick(); cin_n = 1; tick();

        // R4: both in one cycle
        cap = 1; tr = 1; tick(); pulse_idle();
        chk("R4 readout", st, 3); chk("R4 token low", tok_n, 0);
        cin_n = 0; tick(); cin_n = 1; tick();

        // R6: disabled launch
        dis = 1; cap = 1; tick(); cap = 0;
        tr = 1; tick(); tr = 0;
        chk("R6 state", st, 0); chk("R6 token", tok_n, 1);
        dis = 0;

        // R10: clear racing a new orphan event
        tr = 1; tick();
        clr = 1; tick(); pulse_idle();
        chk("R10 set wins", orph, 1);
        clr = 1; tick(); clr = 0;
        chk("R10 orphan cleared", orph, 0);
        cap = 1; tick(); cap = 0; cin_n = 0; tick(); tick(); cin_n = 1;

        // R7: synchroniser latency
        dv_n = 0; tick();
        chk("R7 one edge", dav_n, 1);
        tick();
        chk("R7 two edges", dav_n, 0);
        dv_n = 1; tick(); tick();
        chk("R7 release", dav_n, 1);

        // constrained random against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            cap   = ($urandom_range(0, 9) == 0);
            tr    = ($urandom_range(0, 9) == 0);
            dis   = ($urandom_range(0, 15) == 0);
            clr   = ($urandom_range(0, 19) == 0);
            cin_n = ($urandom_range(0, 5) != 0);
            dv_n  = ($urandom_range(0, 2) != 0);
            model_edge();
            tick();
            chk("R2-R5 random state", st, m_st);
            chk("R6 random token", tok_n, m_tok);
            chk("R8 random overrun", ovr, m_ovr);
            chk("R9 random orphan", orph, m_orph);
            chk("R7 random dav", dav_n, m_dv[SYNC-1]);
        end
        finish_run();
    end
endmodule